// File: doc/BRIEF.md
# Multi-Mode Integer Minimum/Maximum Unit

This unit picks the smaller or larger of two register operands under one of eight modes. A 3-bit mode chooses among three things: the compare width (the full doubleword, or only the low 32-bit word), the number format (unsigned, or two's-complement signed), and the direction (minimum or maximum). Each mode is first reduced to one unsigned less-than test. Word mode moves the low half of each operand to the top. Signed mode flips the top bit. Maximum mode swaps the two compare inputs. The value sent out is always one of the two original full-width sources, even in word mode.

The first operand may come from a register field that reads as zero. In that case the constant zero takes its place in both the compare and the output. When the record bit is set, the unit also writes a 4-bit condition field. The field gives the less, greater or equal relation of the two transformed operands, taken before the maximum swap, followed by the incoming summary-overflow bit. The result, the condition field and its write enable are registered once, so they are valid one clock after the inputs are presented.

Top module: `mmu_minmax`

## Requirements
- R1: The mode is op_mode[2:0]. op_mode[2] set selects the 32-bit word compare, op_mode[1] set selects a signed compare, and op_mode[0] set selects maximum. With op_mode = 000 the output is the unsigned 64-bit minimum, and with 001 it is the unsigned 64-bit maximum.
- R2: With op_mode = 010 the output is the signed 64-bit minimum, and with 011 it is the signed 64-bit maximum. For example, 0x8000_0000_0000_0000 is the smallest signed value and the largest it can be compared against is 0x7FFF_FFFF_FFFF_FFFF.
- R3: With op_mode = 1xx only bits [31:0] of each operand take part in the compare. 100 and 101 compare these bits as unsigned values, and 110 and 111 compare them as signed values.
- R4: The output is always the full 64-bit source that was chosen. In word mode its upper 32 bits are passed through unchanged.
- R5: When the compared values are equal, the output is the second source (src_b).
- R6: When ra_is_zero is 1, the first operand is the constant zero for both the compare and the output, and src_a is ignored.
- R7: When rec_en is 1, cond_out[3:1] is 100 if the transformed first operand is less, 010 if it is greater, and 001 if the two are equal. cond_out[0] is a copy of so_in. The relation does not depend on the min/max bit.
- R8: cond_wr equals rec_en. When rec_en is 0, cond_out is 0000.
- R9: After a clock edge with rst_n low, all outputs are zero. Otherwise, the outputs reflect the inputs sampled at the previous rising clock edge, which gives a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| ra_is_zero | input | 1 | First register field is zero; use constant zero |
| op_mode | input | 3 | {word, signed, max} mode select |
| rec_en | input | 1 | Record bit: write the condition field |
| so_in | input | 1 | Summary-overflow bit appended to the condition field |
| res_out | output | 64 | Selected full-width source |
| cond_out | output | 4 | {lt, gt, eq, so} condition field |
| cond_wr | output | 1 | Condition field write enable |

## Verification
Every result of this unit, the selected value, the condition field and its enable, appears one rising edge after its inputs. The bench changes the inputs on a falling edge and checks them on the falling edge that follows, half a cycle after the capture. One nanosecond after each input change, before the capturing edge, the bench also confirms that the previous output is still held. This shows the latency is exactly one cycle and not zero.

// File: rtl/mm_pkg.sv
// Package: shared mode type and condition-field codes for the min/max unit.
// Assumes the mode vector is packed {word, signed, max} from MSB to LSB.
package mm_pkg;
    typedef struct packed {
        logic word;   // compare low half only
        logic sgn;    // two's-complement compare
        logic max;    // pick larger
    } mm_mode_t;

    localparam int unsigned CF_W = 4;
    localparam logic [2:0] REL_LT = 3'b100;
    localparam logic [2:0] REL_GT = 3'b010;
    localparam logic [2:0] REL_EQ = 3'b001;
endpackage

// File: rtl/mm_xform.sv
// Operand transform: maps one operand onto the unsigned compare domain.
// Assumes W is even; word mode moves the low half to the top.
module mm_xform #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] val,
    input  logic         word,
    input  logic         sgn,
    output logic [W-1:0] xval
);
    localparam int unsigned HALF = W / 2;

    // Shift for word mode, then flip the sign bit for signed mode.
    always_comb begin
        xval = word ? {val[HALF-1:0], {HALF{1'b0}}} : val;
        if (sgn) begin
            xval[W-1] = ~xval[W-1];
        end
    end
endmodule

// File: rtl/mm_cmp.sv
// Unsigned magnitude compare of two transformed operands.
// Assumes both inputs are already in the unsigned compare domain.
module mm_cmp #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] xa,
    input  logic [W-1:0] xb,
    output logic         lt,
    output logic         gt,
    output logic         eq
);
    // Produce the three mutually exclusive relations.
    always_comb begin
        lt = (xa < xb);
        gt = (xa > xb);
        eq = (xa == xb);
    end
endmodule

// File: rtl/mm_select.sv
// Chooses the output source and builds the next condition field.
// Assumes exactly one of lt/gt/eq is set; max swaps the less-than test.
module mm_select
    import mm_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic            lt,
    input  logic            gt,
    input  logic            eq,
    input  logic            is_max,
    input  logic            rec,
    input  logic            so,
    output logic [W-1:0]    res_nx,
    output logic [CF_W-1:0] cond_nx,
    output logic            we_nx
);
    logic take_a;

    // Swapped test for max: b' < a' is the same as a' > b'.
    always_comb begin
        take_a = is_max ? gt : lt;
        res_nx = take_a ? opa : opb;
    end

    // Condition field from the unswapped relation plus summary overflow.
    always_comb begin
        we_nx   = rec;
        cond_nx = '0;
        if (rec) begin
            unique case (1'b1)
                lt:      cond_nx = {REL_LT, so};
                gt:      cond_nx = {REL_GT, so};
                eq:      cond_nx = {REL_EQ, so};
                default: cond_nx = {3'b000, so};
            endcase
        end
    end
endmodule

// File: rtl/mmu_minmax.sv
// Top: eight-mode integer min/max with optional condition field.
// Assumes XLEN is even; outputs are registered once with a synchronous
// active-low reset.
module mmu_minmax
    import mm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            ra_is_zero,
    input  logic [2:0]      op_mode,
    input  logic            rec_en,
    input  logic            so_in,
    output logic [XLEN-1:0] res_out,
    output logic [CF_W-1:0] cond_out,
    output logic            cond_wr
);
    mm_mode_t        md;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] ops  [2];
    logic [XLEN-1:0] xops [2];
    logic            lt, gt, eq;
    logic [XLEN-1:0] res_nx;
    logic [CF_W-1:0] cond_nx;
    logic            we_nx;

    // Decode mode and substitute zero for the first operand when asked.
    always_comb begin
        md     = mm_mode_t'(op_mode);
        opa    = ra_is_zero ? '0 : src_a;
        ops[0] = opa;
        ops[1] = src_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_xf
        mm_xform #(.W(XLEN)) u_xf (
            .val  (ops[g]),
            .word (md.word),
            .sgn  (md.sgn),
            .xval (xops[g])
        );
    end

    mm_cmp #(.W(XLEN)) u_cmp (
        .xa (xops[0]),
        .xb (xops[1]),
        .lt (lt),
        .gt (gt),
        .eq (eq)
    );

    mm_select #(.W(XLEN)) u_sel (
        .opa     (opa),
        .opb     (src_b),
        .lt      (lt),
        .gt      (gt),
        .eq      (eq),
        .is_max  (md.max),
        .rec     (rec_en),
        .so      (so_in),
        .res_nx  (res_nx),
        .cond_nx (cond_nx),
        .we_nx   (we_nx)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out  <= '0;
            cond_out <= '0;
            cond_wr  <= 1'b0;
        end else begin
            res_out  <= res_nx;
            cond_out <= cond_nx;
            cond_wr  <= we_nx;
        end
    end
endmodule

// File: rtl/mm_minmax_chk.sv
// Checker for mmu_minmax: port-level temporal properties.
// Assumes one-cycle latency; checks start one edge after reset release.
module mm_minmax_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic            ra_is_zero,
    input logic            rec_en,
    input logic            so_in,
    input logic [XLEN-1:0] res_out,
    input logic [3:0]      cond_out,
    input logic            cond_wr
);
    logic warm;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    a_r8_we_tracks_rec: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        cond_wr == $past(rec_en));

    a_r8_cond_zero_without_rec: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !cond_wr |-> cond_out == 4'b0000);

    a_r7_one_relation: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        cond_wr |-> $countones(cond_out[3:1]) == 1);

    a_r7_so_copied: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        cond_wr |-> cond_out[0] == $past(so_in));

    a_r4_result_is_source: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        (res_out == $past(src_b)) ||
        (res_out == ($past(ra_is_zero) ? '0 : $past(src_a))));

    a_r5_equal_gives_b: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        (cond_wr && cond_out[1]) |-> res_out == $past(src_b));
endmodule

bind mmu_minmax mm_minmax_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_a      (src_a),
    .src_b      (src_b),
    .ra_is_zero (ra_is_zero),
    .rec_en     (rec_en),
    .so_in      (so_in),
    .res_out    (res_out),
    .cond_out   (cond_out),
    .cond_wr    (cond_wr)
);

// File: tb/sim_mmu_minmax.sv
`timescale 1ns/1ps
module sim_mmu_minmax;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        ra_is_zero = 1'b0;
    logic [2:0]  op_mode = '0;
    logic        rec_en = 1'b0, so_in = 1'b0;
    logic [63:0] res_out;
    logic [3:0]  cond_out;
    logic        cond_wr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mmu_minmax u0 (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .ra_is_zero(ra_is_zero), .op_mode(op_mode), .rec_en(rec_en),
        .so_in(so_in), .res_out(res_out), .cond_out(cond_out), .cond_wr(cond_wr)
    );

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference: -1 less, 0 equal, +1 greater, computed from numeric values.
    function automatic int rel(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m);
        if (m[2]) begin
            if (m[1]) return ($signed(a[31:0]) < $signed(b[31:0])) ? -1 :
                             ($signed(a[31:0]) > $signed(b[31:0])) ? 1 : 0;
            return (a[31:0] < b[31:0]) ? -1 : (a[31:0] > b[31:0]) ? 1 : 0;
        end
        if (m[1]) return ($signed(a) < $signed(b)) ? -1 : ($signed(a) > $signed(b)) ? 1 : 0;
        return (a < b) ? -1 : (a > b) ? 1 : 0;
    endfunction

    task automatic run(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic z, input logic [2:0] m, input logic r, input logic s);
        logic [63:0] prev, ea, er;
        logic [3:0]  ec;
        int          rl;
        @(negedge clk);
        prev = res_out;
        src_a = a; src_b = b; ra_is_zero = z; op_mode = m; rec_en = r; so_in = s;
        #1;
        chk64("R9 hold before edge", res_out, prev);
        ea = z ? 64'd0 : a;
        rl = rel(ea, b, m);
        er = m[0] ? ((rl > 0) ? ea : b) : ((rl < 0) ? ea : b);
        ec = !r ? 4'b0000 : {(rl < 0), (rl > 0), (rl == 0), s};
        @(negedge clk);
        chk64(tag, res_out, er);
        chk64(r ? "R7 cond" : "R8 cond zero", {60'd0, cond_out}, {60'd0, ec});
        chk64("R8 we", {63'd0, cond_wr}, {63'd0, r});
    endtask

    initial begin : watchdog
        #900000;
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        src_a = 64'hDEAD_BEEF_0000_0001; src_b = 64'h1234; rec_en = 1'b1; so_in = 1'b1;
        repeat (3) @(negedge clk);
        chk64("R9 reset res", res_out, 64'd0);
        chk64("R9 reset cond", {59'd0, cond_out, cond_wr}, 64'd0);
        rst_n = 1'b1;

        // Sweep every mode with random operands and flag values.
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 60; i++) begin
                logic [63:0] a, b;
                a = {$urandom, $urandom};
                b = {$urandom, $urandom};
                if (i % 7 == 0) b = {$urandom, a[31:0]};
                run(m[2] ? "R3 word sweep" : (m[1] ? "R2 signed sweep" : "R1 unsigned sweep"),
                    a, b, 1'b0, 3'(m), 1'($urandom), 1'($urandom));
            end
        end

        // Edge cases.
        for (int m = 0; m < 8; m++) begin
            run("R5 equal gives b", 64'hAAAA_0000_5555_1111, 64'hAAAA_0000_5555_1111, 1'b0, 3'(m), 1'b1, 1'b0);
            run("R5 equal low word", 64'h1111_1111_8000_0000, 64'h2222_2222_8000_0000, 1'b0, 3'(m), 1'b1, 1'b1);
            run("R2 most negative", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 3'(m), 1'b1, 1'b0);
            run("R1 all ones", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, 3'(m), 1'b1, 1'b0);
            run("R4 upper halves kept", 64'hFFFF_0000_0000_0005, 64'h0000_FFFF_8000_0000, 1'b0, 3'(m), 1'b0, 1'b0);
            run("R6 zero ra", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'(m), 1'b1, 1'b1);
            run("R6 zero ra pos", 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0002, 1'b1, 3'(m), 1'b1, 1'b0);
        end

        // Reset reasserted mid-stream.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk64("R9 re-reset", {res_out[59:0], cond_out}, 64'd0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule